// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a peripheral bus. It lets a processor reach device configuration space through a pair of I/O ports. The host first writes a pointer into the address port at I/O location 0x0CF8. Later reads and writes to the data port at 0x0CFC are turned into configuration read or write cycles. Each cycle carries the matching command code and a doubleword bus address built from the stored pointer.

Any other I/O location goes out unchanged on a separate I/O request port. A data-port access also goes out there when the pointer's enable bit (bit 31) is clear. If no pointer has been written since reset, a data-port access is answered locally with all ones.

The host holds its request until the bridge returns a one-cycle ready pulse. The bridge raises that pulse only after the downstream side has acknowledged. The downstream configuration and I/O sides are plain request/acknowledge ports. Each request is held until acknowledged.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset, host_ready, cfg_req and io_req are low, and a read of the address port returns 0.
- R2: A write to I/O address 0x0CF8 stores the full 32-bit value. A later read of 0x0CF8 returns that value. Neither access raises cfg_req or io_req.
- R3: A read or write of 0x0CFC before any write to 0x0CF8 since reset raises no downstream request. The read returns 0xFFFFFFFF.
- R4: A read of 0x0CFC while stored bit 31 is 1 raises cfg_req with cfg_cmd = 4'b1010.
- R5: A write of 0x0CFC while stored bit 31 is 1 raises cfg_req with cfg_cmd = 4'b1011 and cfg_wdata equal to the host write data.
- R6: cfg_addr bits 1:0 are 0. Bits 7:2 equal stored pointer bits 7:2 (register number). Bits 10:8 equal stored pointer bits 10:8 (function). Bits 31:11 are 0.
- R7: An access to 0x0CFC while a pointer has been written but its bit 31 is 0 goes out on the I/O port with io_addr = 0x0CFC, and cfg_req stays low.
- R8: An access to any I/O address other than 0x0CF8 and 0x0CFC goes out on the I/O port with the same address, direction and write data. A read returns io_rdata.
- R9: host_ready stays low while a downstream request is outstanding. On a configuration read, host_rdata carries cfg_rdata as taken with cfg_ack. The ready pulse comes one cycle after the acknowledge cycle.
- R10: cfg_req, cfg_cmd and cfg_addr stay unchanged from the cycle cfg_req rises until cfg_ack is seen.
- R11: host_ready is a single-cycle pulse, given once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host I/O request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | IO_AW | Host I/O byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | One-cycle completion pulse |
| cfg_req | output | 1 | Configuration cycle request, held until cfg_ack |
| cfg_cmd | output | 4 | Bus command code (1010 read, 1011 write) |
| cfg_addr | output | 32 | Formatted configuration bus address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Configuration cycle done |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |
| io_req | output | 1 | Plain I/O request, held until io_ack |
| io_we | output | 1 | Plain I/O direction |
| io_addr | output | IO_AW | Plain I/O address |
| io_wdata | output | 32 | Plain I/O write data |
| io_ack | input | 1 | Plain I/O done |
| io_rdata | input | 32 | Plain I/O read data, valid with io_ack |

## Verification
The bench probes the data port before any pointer is written. A design that skipped the written flag would emit a stray configuration cycle or return a stale value instead of all ones.

It loads pointers with junk in bits 30:11 and 1:0. This catches address formatting that leaks those bits onto the bus, or that shifts the register and function fields.

A pointer with the enable bit clear must be routed to the plain I/O port. A bridge that ignored the enable bit would wrongly issue a configuration command.

Downstream latencies of one and several cycles are used. Early or repeated ready pulses, and request fields that drift before the acknowledge, show up as wrong cycle counts or changed captures.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int unsigned CFGB_DW     = 32;
  localparam int unsigned CFGB_EN_BIT = 31;
  localparam logic [3:0]  CMD_CFG_RD  = 4'b1010;
  localparam logic [3:0]  CMD_CFG_WR  = 4'b1011;

  typedef enum logic [1:0] {
    ROUTE_PTR   = 2'd0,
    ROUTE_BLANK = 2'd1,
    ROUTE_CFG   = 2'd2,
    ROUTE_IO    = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_IO   = 2'd2,
    ST_RESP = 2'd3
  } seq_e;

  // Doubleword configuration address: function and register fields kept, rest cleared
  function automatic logic [CFGB_DW-1:0] cfg_bus_addr(input logic [CFGB_DW-1:0] ptr);
    logic [CFGB_DW-1:0] a;
    a        = '0;
    a[10:8]  = ptr[10:8];
    a[7:2]   = ptr[7:2];
    return a;
  endfunction

  function automatic logic [3:0] cfg_cmd_of(input logic is_write);
    return is_write ? CMD_CFG_WR : CMD_CFG_RD;
  endfunction
endpackage

// File: rtl/cfgb_ptr_reg.sv
module cfgb_ptr_reg
  import cfgb_pkg::*;
#(
  parameter int unsigned DW = CFGB_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ptr_q,
  output logic          written_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      written_q <= 1'b0;
    end else if (wr_en) begin
      ptr_q     <= wdata;
      written_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgb_route.sv
module cfgb_route
  import cfgb_pkg::*;
#(
  parameter int unsigned    IO_AW     = 16,
  parameter logic [IO_AW-1:0] PTR_PORT  = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic [IO_AW-1:0] host_addr,
  input  logic             written,
  input  logic             enable,
  output route_e           route
);
  always_comb begin
    if (host_addr == PTR_PORT)       route = ROUTE_PTR;
    else if (host_addr != DATA_PORT) route = ROUTE_IO;
    else if (!written)               route = ROUTE_BLANK;
    else if (enable)                 route = ROUTE_CFG;
    else                             route = ROUTE_IO;
  end
endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
  import cfgb_pkg::*;
#(
  parameter int unsigned IO_AW = 16,
  parameter int unsigned DW    = CFGB_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic [IO_AW-1:0] host_addr,
  input  logic [DW-1:0]    host_wdata,
  input  route_e           route,
  input  logic [DW-1:0]    ptr_q,
  output logic [DW-1:0]    host_rdata,
  output logic             host_ready,
  output logic             cfg_req,
  output logic [3:0]       cfg_cmd,
  output logic [DW-1:0]    cfg_addr,
  output logic [DW-1:0]    cfg_wdata,
  input  logic             cfg_ack,
  input  logic [DW-1:0]    cfg_rdata,
  output logic             io_req,
  output logic             io_we,
  output logic [IO_AW-1:0] io_addr,
  output logic [DW-1:0]    io_wdata,
  input  logic             io_ack,
  input  logic [DW-1:0]    io_rdata,
  output logic             accept_evt,
  output logic             ptr_wr_evt
);
  seq_e             state_q;
  logic             we_q;
  logic [IO_AW-1:0] addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    cfgaddr_q;
  logic [DW-1:0]    rdata_q;

  assign accept_evt = (state_q == ST_IDLE) && host_req;
  assign ptr_wr_evt = accept_evt && host_we && (route == ROUTE_PTR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      cfgaddr_q <= '0;
      rdata_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (host_req) begin
          we_q    <= host_we;
          addr_q  <= host_addr;
          wdata_q <= host_wdata;
          case (route)
            ROUTE_PTR: begin
              rdata_q <= host_we ? '0 : ptr_q;
              state_q <= ST_RESP;
            end
            ROUTE_BLANK: begin
              rdata_q <= host_we ? '0 : '1;
              state_q <= ST_RESP;
            end
            ROUTE_CFG: begin
              cfgaddr_q <= cfg_bus_addr(ptr_q);
              state_q   <= ST_CFG;
            end
            default: state_q <= ST_IO;
          endcase
        end
        ST_CFG: if (cfg_ack) begin
          rdata_q <= we_q ? '0 : cfg_rdata;
          state_q <= ST_RESP;
        end
        ST_IO: if (io_ack) begin
          rdata_q <= we_q ? '0 : io_rdata;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign host_ready = (state_q == ST_RESP);
  assign host_rdata = rdata_q;
  assign cfg_req    = (state_q == ST_CFG);
  assign cfg_cmd    = cfg_cmd_of(we_q);
  assign cfg_addr   = cfgaddr_q;
  assign cfg_wdata  = wdata_q;
  assign io_req     = (state_q == ST_IO);
  assign io_we      = we_q;
  assign io_addr    = addr_q;
  assign io_wdata   = wdata_q;
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter int unsigned      IO_AW     = 16,
  parameter logic [IO_AW-1:0] PTR_PORT  = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic [IO_AW-1:0] host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             host_ready,
  output logic             cfg_req,
  output logic [3:0]       cfg_cmd,
  output logic [31:0]      cfg_addr,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_ack,
  input  logic [31:0]      cfg_rdata,
  output logic             io_req,
  output logic             io_we,
  output logic [IO_AW-1:0] io_addr,
  output logic [31:0]      io_wdata,
  input  logic             io_ack,
  input  logic [31:0]      io_rdata
);
  localparam int unsigned DW = CFGB_DW;

  logic [DW-1:0] ptr_q;
  logic          written_q;
  route_e        route;
  logic          accept_evt;
  logic          ptr_wr_evt;

  cfgb_ptr_reg #(.DW(DW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ptr_wr_evt),
    .wdata     (host_wdata),
    .ptr_q     (ptr_q),
    .written_q (written_q)
  );

  cfgb_route #(.IO_AW(IO_AW), .PTR_PORT(PTR_PORT), .DATA_PORT(DATA_PORT)) u_route (
    .host_addr (host_addr),
    .written   (written_q),
    .enable    (ptr_q[CFGB_EN_BIT]),
    .route     (route)
  );

  cfgb_seq #(.IO_AW(IO_AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .route      (route),
    .ptr_q      (ptr_q),
    .host_rdata (host_rdata),
    .host_ready (host_ready),
    .cfg_req    (cfg_req),
    .cfg_cmd    (cfg_cmd),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_ack    (cfg_ack),
    .cfg_rdata  (cfg_rdata),
    .io_req     (io_req),
    .io_we      (io_we),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_ack     (io_ack),
    .io_rdata   (io_rdata),
    .accept_evt (accept_evt),
    .ptr_wr_evt (ptr_wr_evt)
  );
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker
  import cfgb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] host_wdata,
  input logic [31:0] host_rdata,
  input logic        host_ready,
  input logic        cfg_req,
  input logic [3:0]  cfg_cmd,
  input logic [31:0] cfg_addr,
  input logic        cfg_ack,
  input logic        io_req,
  input logic [31:0] ptr_q,
  input route_e      route,
  input logic        accept_evt,
  input logic        ptr_wr_evt
);
  // R2
  ptr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_evt |=> ptr_q == $past(host_wdata));

  // R3
  blank_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && route == ROUTE_BLANK) |=> (host_ready && !cfg_req && !io_req));

  // R4
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_cmd == CMD_CFG_RD || cfg_cmd == CMD_CFG_WR));

  // R6
  addr_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_addr[1:0] == 2'b00 && cfg_addr[31:11] == '0));

  // R7
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && io_req));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req || io_req) |-> !host_ready);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_cmd)));

  // R11
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  // R3
  blank_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && route == ROUTE_BLANK && !ptr_wr_evt) |=> (host_rdata == '1 || host_rdata == '0));
endmodule

bind cfg_port_bridge cfgb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .host_ready (host_ready),
  .cfg_req    (cfg_req),
  .cfg_cmd    (cfg_cmd),
  .cfg_addr   (cfg_addr),
  .cfg_ack    (cfg_ack),
  .io_req     (io_req),
  .ptr_q      (ptr_q),
  .route      (route),
  .accept_evt (accept_evt),
  .ptr_wr_evt (ptr_wr_evt)
);

// File: tb/cfg_port_bridge_test.sv
module cfg_port_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ready;
  logic        cfg_req;
  logic [3:0]  cfg_cmd;
  logic [31:0] cfg_addr, cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic        io_req, io_we;
  logic [15:0] io_addr;
  logic [31:0] io_wdata;
  logic        io_ack = 1'b0;
  logic [31:0] io_rdata = '0;

  int checks = 0;
  int errors = 0;
  int lat = 3;
  int cfg_seen = 0, io_seen = 0, cfg_wait = 0, io_wait = 0;
  logic [3:0]  cap_cmd;
  logic [31:0] cap_caddr, cap_cwdata, cap_iwdata;
  logic [15:0] cap_iaddr;
  logic        cap_iwe;
  bit          drift = 1'b0;

  always #5 clk = ~clk;

  cfg_port_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .cfg_req(cfg_req), .cfg_cmd(cfg_cmd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
    .cfg_rdata(cfg_rdata), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata)
  );

  function automatic logic [31:0] dev_cfg_val(input logic [31:0] a);
    return 32'hC0DE_0000 ^ a;
  endfunction
  function automatic logic [31:0] dev_io_val(input logic [15:0] a);
    return {16'h5A00, a};
  endfunction
  function automatic logic [31:0] expect_bus(input logic [31:0] p);
    return ((p >> 8) & 32'h7) << 8 | ((p >> 2) & 32'h3F) << 2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // downstream responders
  initial forever begin
    @(negedge clk);
    if (cfg_req) begin
      if (cfg_wait == 0) begin
        cfg_seen++;
        cap_cmd = cfg_cmd; cap_caddr = cfg_addr; cap_cwdata = cfg_wdata;
      end else if (cfg_cmd !== cap_cmd || cfg_addr !== cap_caddr) drift = 1'b1;
      cfg_wait++;
      cfg_ack   = (cfg_wait == lat);
      cfg_rdata = dev_cfg_val(cfg_addr);
    end else begin
      cfg_ack = 1'b0; cfg_wait = 0;
    end
    if (io_req) begin
      if (io_wait == 0) begin
        io_seen++;
        cap_iaddr = io_addr; cap_iwe = io_we; cap_iwdata = io_wdata;
      end
      io_wait++;
      io_ack   = (io_wait == lat);
      io_rdata = dev_io_val(io_addr);
    end else begin
      io_ack = 1'b0; io_wait = 0;
    end
  end

  // one host access; returns read data and cycles to ready
  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int cyc);
    cfg_seen = 0; io_seen = 0;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!host_ready && cyc < 100);
    if (!host_ready) begin
      errors++;
      $display("FAIL R9: no ready, actual timeout expected pulse");
    end
    rd = host_rdata;
    host_req = 1'b0;
    @(negedge clk);
    check("R11 single pulse", {31'd0, host_ready}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] rd; int cyc;
    check("R1 ready low", {31'd0, host_ready}, 32'd0);
    check("R1 cfg_req low", {31'd0, cfg_req}, 32'd0);
    check("R1 io_req low", {31'd0, io_req}, 32'd0);
    access(1'b0, 16'h0CF8, '0, rd, cyc);
    check("R1 pointer reads 0", rd, 32'd0);
  endtask

  task automatic t_blank();
    logic [31:0] rd; int cyc;
    access(1'b0, 16'h0CFC, '0, rd, cyc);
    check("R3 blank read ones", rd, 32'hFFFF_FFFF);
    check("R3 no downstream on read", cfg_seen + io_seen, 0);
    access(1'b1, 16'h0CFC, 32'h1111_2222, rd, cyc);
    check("R3 no downstream on write", cfg_seen + io_seen, 0);
  endtask

  task automatic t_other_io();
    logic [31:0] rd; int cyc;
    access(1'b1, 16'h0080, 32'hDEAD_BEEF, rd, cyc);
    check("R8 write forwarded", io_seen, 1);
    check("R8 io addr", {16'd0, cap_iaddr}, 32'h0080);
    check("R8 io we", {31'd0, cap_iwe}, 32'd1);
    check("R8 io wdata", cap_iwdata, 32'hDEAD_BEEF);
    access(1'b0, 16'h03F8, '0, rd, cyc);
    check("R8 read data", rd, dev_io_val(16'h03F8));
    check("R8 no cfg", cfg_seen, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] rd; int cyc;
    access(1'b1, 16'h0CF8, 32'h0000_0A10, rd, cyc);
    check("R2 ptr write no downstream", cfg_seen + io_seen, 0);
    access(1'b0, 16'h0CF8, '0, rd, cyc);
    check("R2 ptr readback", rd, 32'h0000_0A10);
    access(1'b0, 16'h0CFC, '0, rd, cyc);
    check("R7 no cfg cycle", cfg_seen, 0);
    check("R7 forwarded", io_seen, 1);
    check("R7 io addr", {16'd0, cap_iaddr}, 32'h0CFC);
    check("R7 read data", rd, dev_io_val(16'h0CFC));
  endtask

  task automatic t_cfg_read(input int l);
    logic [31:0] rd; int cyc;
    logic [31:0] p;
    p = 32'h8000_0534;
    lat = l;
    access(1'b1, 16'h0CF8, p, rd, cyc);
    access(1'b0, 16'h0CFC, '0, rd, cyc);
    check("R4 one cfg cycle", cfg_seen, 1);
    check("R4 read cmd", {28'd0, cap_cmd}, 32'hA);
    check("R6 read address", cap_caddr, expect_bus(p));
    check("R9 read data", rd, dev_cfg_val(expect_bus(p)));
    check("R9 stall cycles", cyc, l + 1);
  endtask

  task automatic t_cfg_write(input int l);
    logic [31:0] rd; int cyc;
    logic [31:0] p;
    p = 32'hFFFF_F7FF;
    lat = l;
    access(1'b1, 16'h0CF8, p, rd, cyc);
    access(1'b1, 16'h0CFC, 32'h1234_5678, rd, cyc);
    check("R5 one cfg cycle", cfg_seen, 1);
    check("R5 write cmd", {28'd0, cap_cmd}, 32'hB);
    check("R5 write data", cap_cwdata, 32'h1234_5678);
    check("R6 write address", cap_caddr, 32'h0000_07FC);
    check("R6 model agrees", cap_caddr, expect_bus(p));
    check("R7 no io on cfg", io_seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_blank();
    t_other_io();
    t_disabled();
    t_cfg_read(1);
    t_cfg_read(6);
    t_cfg_write(4);
    check("R10 request held stable", {31'd0, drift}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule